// File: doc/BRIEF.md
# AUX Request Frame Assembler

This block turns one AUX channel request into the ordered byte stream that a transmit buffer expects. A requester presents a 4-bit command, a 20-bit target address, a payload length, a defer value and up to sixteen payload bytes as one flat vector. The block takes all of these in a single handshake cycle and stores them. It then streams the frame out one byte per cycle under a valid/ready handshake.

A frame always begins with three header bytes. The first byte packs the command with the top address nibble, and the next two carry the rest of the address. A length byte follows when the length is nonzero. Payload bytes are appended only for write-type commands. The block also publishes the total frame size in bytes and a start delay derived from the defer value, both held stable for the rest of the frame.

A length above the supported maximum is refused. The block raises an error pulse, sends no bytes and keeps its published values. A one-cycle done pulse marks the handoff of the final byte. New requests are taken only while no frame is in progress.

Top module: `aux_req_framer`

## Requirements
- R1: The first byte sent is `{req_cmd, req_addr[19:16]}`, with the command in bits 7:4.
- R2: The second byte is `req_addr[15:8]` and the third is `req_addr[7:0]`.
- R3: When `req_len` is nonzero, a fourth byte equal to `req_len - 1` follows the address. When `req_len` is zero, no length byte is sent.
- R4: Payload bytes follow the header only for the write-type command codes 4'b1000, 4'b0000 and 4'b0100. Payload byte k is taken from `req_payload[8k+7:8k]`, in order from k = 0. Every other command code sends no payload.
- R5: After acceptance, `frame_bytes` holds (4 if length nonzero, else 3), plus the length for write-type commands. This value equals the number of bytes the frame sends.
- R6: After acceptance, `start_delay` holds `req_defer * 10`.
- R7: `req_ready` is high exactly when no frame is in progress, and a request offered while it is low has no effect. Once `out_valid` is high it stays high, with `out_data` and `out_last` unchanged, until `out_ready` takes the byte.
- R8: `out_last` marks the final byte of a frame. `done` is high for exactly one cycle, the cycle after that byte is taken.
- R9: A request with `req_len` above 16 raises `len_err` for one cycle in the next cycle. It sends no bytes and leaves `frame_bytes` and `start_delay` unchanged.
- R10: In reset, `req_ready` is 1 and `out_valid`, `done`, `len_err`, `frame_bytes` and `start_delay` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle; request taken when both high |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload length (0..16 legal) |
| req_defer | input | 8 | Defer value for the start delay |
| req_payload | input | 128 | Payload bytes, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| frame_bytes | output | 5 | Total bytes in the current frame |
| start_delay | output | 12 | Defer value times ten |
| done | output | 1 | One-cycle pulse after the final byte |
| len_err | output | 1 | One-cycle pulse for a refused length |

## Verification
The assertions assume the request fields matter only in the cycle of acceptance, so the bench changes them freely at every other time. The assertions also assume `out_ready` may fall or rise in any cycle. The stimulus therefore scrambles the request fields after each handshake. It drives a request while a frame is still streaming, throttles `out_ready` at random for part of the run, and sends lengths of 0, 1, 16, 17 and 31. The defer value stays within its 8-bit port, so the ten-times product always fits the delay output.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;
  localparam int CMD_W     = 4;
  localparam int ADDR_W    = 20;
  localparam int BYTE_W    = 8;
  localparam int HDR_SHORT = 3;
  localparam int HDR_LONG  = 4;

  localparam logic [CMD_W-1:0] CMD_NAT_WR     = 4'b1000;
  localparam logic [CMD_W-1:0] CMD_I2C_WR     = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_I2C_WR_MOT = 4'b0100;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SEND = 1'b1} seq_state_e;

  function automatic logic carries_payload(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_NAT_WR) || (cmd == CMD_I2C_WR) || (cmd == CMD_I2C_WR_MOT);
  endfunction
endpackage

// File: rtl/aux_frm_plan.sv
module aux_frm_plan
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 5
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             len_ok_o,
  output logic             wr_o,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] hdr_cnt;
  logic [CNT_W-1:0] body_cnt;

  always_comb begin
    wr_o     = carries_payload(cmd_i);
    len_ok_o = (len_i <= LEN_W'(MAX_LEN));
    hdr_cnt  = (len_i == '0) ? CNT_W'(HDR_SHORT) : CNT_W'(HDR_LONG);
    body_cnt = wr_o ? CNT_W'(len_i) : '0;
    total_o  = hdr_cnt + body_cnt;
  end
endmodule

// File: rtl/aux_frm_store.sv
module aux_frm_store
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int PIDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [MAX_LEN*BYTE_W-1:0] data_i,
  input  logic [PIDX_W-1:0]         idx_i,
  output logic [BYTE_W-1:0]         byte_o
);
  logic [MAX_LEN*BYTE_W-1:0] slots_flat;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    logic [BYTE_W-1:0] slot_n;

    always_comb begin
      slot_n = slot_q;
      if (load_i) slot_n = data_i[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_n;
    end

    assign slots_flat[g*BYTE_W +: BYTE_W] = slot_q;
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (idx_i == PIDX_W'(k)) byte_o = slots_flat[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr
  import aux_frm_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] pl_byte_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] len_byte;

  always_comb begin
    len_byte = BYTE_W'(len_i - LEN_W'(1));
    case (idx_i)
      CNT_W'(0): byte_o = {cmd_i, addr_i[19:16]};
      CNT_W'(1): byte_o = addr_i[15:8];
      CNT_W'(2): byte_o = addr_i[7:0];
      CNT_W'(3): byte_o = (len_i != '0) ? len_byte : pl_byte_i;
      default:   byte_o = pl_byte_i;
    endcase
  end
endmodule

// File: rtl/aux_frm_seq.sv
module aux_frm_seq
  import aux_frm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             done_o
);
  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] idx_q, idx_n;
  logic             done_q, done_n;

  always_comb begin
    valid_o = (state_q == SEQ_SEND);
    last_o  = valid_o && (idx_q == total_i - CNT_W'(1));
    idx_o   = idx_q;
    done_o  = done_q;
  end

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_n = SEQ_SEND;
          idx_n   = '0;
        end
      end
      SEQ_SEND: begin
        if (ready_i) begin
          if (last_o) begin
            state_n = SEQ_IDLE;
            done_n  = 1'b1;
          end else begin
            idx_n = idx_q + CNT_W'(1);
          end
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_frm_pkg::*;
#(
  parameter  int MAX_LEN   = 16,
  parameter  int LEN_W     = 5,
  parameter  int DEFER_W   = 8,
  parameter  int DELAY_MUL = 10,
  localparam int CNT_W     = $clog2(HDR_LONG + MAX_LEN + 1),
  localparam int PIDX_W    = $clog2(MAX_LEN),
  localparam int DLY_W     = DEFER_W + $clog2(DELAY_MUL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [CMD_W-1:0]          req_cmd,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [DEFER_W-1:0]        req_defer,
  input  logic [MAX_LEN*BYTE_W-1:0] req_payload,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [BYTE_W-1:0]         out_data,
  output logic                      out_last,
  output logic [CNT_W-1:0]          frame_bytes,
  output logic [DLY_W-1:0]          start_delay,
  output logic                      done,
  output logic                      len_err
);
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [CNT_W-1:0]  total_q, total_n;
  logic [DLY_W-1:0]  dly_q, dly_n;
  logic              err_q, err_n;

  logic              accept, load;
  logic              len_ok, wr_cmd;
  logic [CNT_W-1:0]  total_c;
  logic [CNT_W-1:0]  idx, pl_off;
  logic [BYTE_W-1:0] pl_byte;

  aux_frm_plan #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_plan (
    .cmd_i(req_cmd), .len_i(req_len),
    .len_ok_o(len_ok), .wr_o(wr_cmd), .total_o(total_c)
  );

  always_comb begin
    accept  = req_valid && req_ready;
    load    = accept && len_ok;
    cmd_n   = load ? req_cmd : cmd_q;
    addr_n  = load ? req_addr : addr_q;
    len_n   = load ? req_len : len_q;
    total_n = load ? total_c : total_q;
    dly_n   = load ? (DLY_W'(req_defer) * DLY_W'(DELAY_MUL)) : dly_q;
    err_n   = accept && !len_ok;
    pl_off  = idx - CNT_W'(HDR_LONG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      total_q <= '0;
      dly_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      len_q   <= len_n;
      total_q <= total_n;
      dly_q   <= dly_n;
      err_q   <= err_n;
    end
  end

  aux_frm_store #(.MAX_LEN(MAX_LEN), .PIDX_W(PIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(req_payload),
    .idx_i(pl_off[PIDX_W-1:0]), .byte_o(pl_byte)
  );

  aux_frm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(load), .ready_i(out_ready),
    .total_i(total_q), .valid_o(out_valid), .idx_o(idx),
    .last_o(out_last), .done_o(done)
  );

  aux_frm_hdr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .cmd_i(cmd_q), .addr_i(addr_q), .len_i(len_q), .idx_i(idx),
    .pl_byte_i(pl_byte), .byte_o(out_data)
  );

  assign req_ready   = !out_valid;
  assign frame_bytes = total_q;
  assign start_delay = dly_q;
  assign len_err     = err_q;
endmodule

// File: rtl/aux_frm_chk.sv
module aux_frm_chk #(
  parameter int MAX_LEN   = 16,
  parameter int LEN_W     = 5,
  parameter int DEFER_W   = 8,
  parameter int DELAY_MUL = 10,
  parameter int CNT_W     = 5,
  parameter int DLY_W     = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [3:0]         req_cmd,
  input logic [19:0]        req_addr,
  input logic [LEN_W-1:0]   req_len,
  input logic [DEFER_W-1:0] req_defer,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data,
  input logic               out_last,
  input logic [CNT_W-1:0]   frame_bytes,
  input logic [DLY_W-1:0]   start_delay,
  input logic               done,
  input logic               len_err
);
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len <= LEN_W'(MAX_LEN)))
      |=> (out_valid && out_data == {$past(req_cmd), $past(req_addr[19:16])}));

  a_r6_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len <= LEN_W'(MAX_LEN)))
      |=> (start_delay == DLY_W'($past(req_defer)) * DLY_W'(DELAY_MUL)));

  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len > LEN_W'(MAX_LEN)))
      |=> (len_err && !out_valid && $stable(frame_bytes) && $stable(start_delay)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bytes <= CNT_W'(4 + MAX_LEN));
endmodule

bind aux_req_framer aux_frm_chk #(
  .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .DEFER_W(DEFER_W),
  .DELAY_MUL(DELAY_MUL), .CNT_W(CNT_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_defer(req_defer),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .frame_bytes(frame_bytes), .start_delay(start_delay),
  .done(done), .len_err(len_err)
);

// File: tb/sim_aux_req_framer.sv
module sim_aux_req_framer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [7:0]   req_defer = '0;
  logic [127:0] req_payload = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [7:0]   out_data;
  logic         out_last;
  logic [4:0]   frame_bytes;
  logic [11:0]  start_delay;
  logic         done;
  logic         len_err;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  rdy_mode = 1'b0;
  bit  ended = 1'b0;

  // reference model state
  byte unsigned q_data[$];
  string        q_tag[$];
  bit           m_busy, m_done, m_err;
  int           m_fb, m_dly;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_framer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .req_defer(req_defer), .req_payload(req_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .frame_bytes(frame_bytes), .start_delay(start_delay),
    .done(done), .len_err(len_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data.delete(); q_tag.delete();
      m_busy = 0; m_done = 0; m_err = 0; m_fb = 0; m_dly = 0;
    end else begin
      m_done = 0;
      m_err  = 0;
      if (!m_busy) begin
        if (req_valid) begin
          if (req_len > 16) m_err = 1;
          else begin
            bit wr;
            wr = (req_cmd == 4'h8) || (req_cmd == 4'h0) || (req_cmd == 4'h4);
            q_data.push_back({req_cmd, req_addr[19:16]}); q_tag.push_back("R1");
            q_data.push_back(req_addr[15:8]);             q_tag.push_back("R2");
            q_data.push_back(req_addr[7:0]);              q_tag.push_back("R2");
            if (req_len != 0) begin
              q_data.push_back(8'(req_len - 1)); q_tag.push_back("R3");
            end
            if (wr) begin
              for (int k = 0; k < int'(req_len); k++) begin
                q_data.push_back(req_payload[k*8 +: 8]); q_tag.push_back("R4");
              end
            end
            m_fb   = q_data.size();
            m_dly  = int'(req_defer) * 10;
            m_busy = 1;
          end
        end
      end else if (out_ready) begin
        void'(q_data.pop_front());
        void'(q_tag.pop_front());
        if (q_data.size() == 0) begin
          m_busy = 0;
          m_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R7 ready", int'(req_ready), int'(!m_busy));
      chk("R7 valid", int'(out_valid), int'(m_busy));
      if (m_busy) begin
        chk(q_tag[0], int'(out_data), int'(q_data[0]));
        chk("R8 last", int'(out_last), int'(q_data.size() == 1));
      end
      chk("R8 done", int'(done), int'(m_done));
      chk("R9 len_err", int'(len_err), int'(m_err));
      chk("R5 frame_bytes", int'(frame_bytes), m_fb);
      chk("R6 start_delay", int'(start_delay), m_dly);
    end
  end

  always @(negedge clk) out_ready = rdy_mode ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic scramble();
    req_cmd = 4'($urandom); req_addr = 20'($urandom); req_len = 5'($urandom);
    req_defer = 8'($urandom);
    for (int k = 0; k < 4; k++) req_payload[k*32 +: 32] = $urandom;
  endtask

  task automatic issue(input logic [3:0] c, input logic [19:0] a,
                       input logic [4:0] l, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < 4; k++) req_payload[k*32 +: 32] = $urandom;
    req_cmd = c; req_addr = a; req_len = l; req_defer = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    scramble();
  endtask

  task automatic drain();
    @(negedge clk);
    while (!req_ready || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 ready", int'(req_ready), 1);
    chk("R10 valid", int'(out_valid), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 len_err", int'(len_err), 0);
    chk("R10 frame_bytes", int'(frame_bytes), 0);
    chk("R10 start_delay", int'(start_delay), 0);
    rst_n = 1'b1;

    issue(4'h8, 20'hABCDE, 5'd0, 8'd0);    // R3: write, no length byte
    issue(4'h9, 20'h12345, 5'd16, 8'd255); // R4: read, header only
    issue(4'h8, 20'hF0F0F, 5'd16, 8'd7);   // R4: longest write
    issue(4'h0, 20'h00050, 5'd1, 8'd1);    // R4: single-byte write
    issue(4'h4, 20'h80001, 5'd5, 8'd3);    // R4: write, middle of transaction
    issue(4'h5, 20'h0A0A0, 5'd3, 8'd9);
    issue(4'h2, 20'h77777, 5'd2, 8'd4);    // R4: non-write code
    issue(4'h8, 20'h11111, 5'd17, 8'd50);  // R9
    issue(4'h0, 20'h22222, 5'd31, 8'd60);  // R9
    drain();

    // R7: request while busy is ignored
    rdy_mode = 1'b1;
    issue(4'h8, 20'h3C3C3, 5'd12, 8'd20);
    req_cmd = 4'h9; req_addr = 20'h55555; req_len = 5'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();

    for (int i = 0; i < 60; i++) begin
      logic [4:0] l;
      l = (i % 7 == 0) ? 5'($urandom_range(17, 31)) : 5'($urandom_range(0, 16));
      rdy_mode = (i % 3 != 0);
      issue(4'($urandom), 20'($urandom), l, 8'($urandom));
    end
    drain();
    finish_run();
  end
endmodule